// File: doc/BRIEF.md
# Two-Level Random Early Drop Admission

This block makes the keep-or-discard call for every frame that arrives at one egress port with several prioritized queues. On each arrival it takes the occupancy of the target queue, in buffer granules. It compares that occupancy with two programmable levels for that queue, a lower level and an upper level. Each level is programmed in units of 16 granules. If the occupancy is above either level, the block draws a pseudo-random number. It drops the frame with a probability set by the crossed level and by the frame's drop-precedence bit.

At the lower level, frames marked high-drop and frames marked low-drop each have their own percentage. At the upper level, high-drop frames are always discarded. Low-drop frames at the upper level are dropped with a third percentage. Queue 0 is never policed.

The decision comes out registered, with a valid flag, in the cycle after the arrival strobe. The random source is a free-running 16-bit LFSR inside the block. The buffer manager samples the decision and either stores the frame or discards it.

Top module: `wred_admit`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, `dec_vld` and `dec_drop` are 0. Reset also loads the LFSR with 16'hACE1.
- R2: `dec_vld` is 1 in exactly the cycle after a cycle with `arr_vld` high, and 0 otherwise. Arrivals in back-to-back cycles each produce their own decision.
- R3: A frame for queue 0 is always accepted, whatever the occupancy and the levels.
- R4: A frame for queue q > 0 is accepted when its occupancy is at or below both 16·L1[q] and 16·L2[q]. A level is crossed only when the occupancy strictly exceeds it.
- R5: When the occupancy is above 16·L1[q] but not above 16·L2[q], a high-drop frame (`arr_hi_drop`=1) is dropped when the draw is below `pct_x`. A low-drop frame is dropped when the draw is below `pct_y`.
- R6: When the occupancy is above 16·L2[q], a high-drop frame is always dropped. The upper level is tested first, whatever L1[q] holds.
- R7: When the occupancy is above 16·L2[q], a low-drop frame is dropped when the draw is below `pct_z`.
- R8: The LFSR advances on every clock out of reset. Its next state is {s[14:0], s[15]^s[13]^s[12]^s[10]}. The draw for an arrival is taken from the state held in the arrival cycle: r = s[6:0], minus 100 if r ≥ 100. A percentage of 0 never drops and a percentage of 100 always drops.
- R9: `dec_drop` is 0 whenever `dec_vld` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| arr_vld | input | 1 | Frame arrival strobe |
| arr_queue | input | QW | Target queue index |
| arr_hi_drop | input | 1 | 1 = high drop precedence, 0 = low |
| occ_flat | input | NQ·OCC_W | Occupancy per queue in granules; queue q at bits [q·OCC_W +: OCC_W] |
| l1_flat | input | NQ·THR_W | Lower level per queue, units of 16 granules (queue 0 slot unused) |
| l2_flat | input | NQ·THR_W | Upper level per queue, units of 16 granules (queue 0 slot unused) |
| pct_x | input | PCT_W | Drop percentage for high-drop frames at the lower level |
| pct_y | input | PCT_W | Drop percentage for low-drop frames at the lower level |
| pct_z | input | PCT_W | Drop percentage for low-drop frames at the upper level |
| dec_vld | output | 1 | Decision valid, one cycle after arrival |
| dec_drop | output | 1 | 1 = discard the frame |

## Verification
Two things happen at the same clock edge: the registered decision for one arrival, and the LFSR step that feeds the draw for the next arrival. The bench provokes this by presenting an arrival on every consecutive cycle during its occupancy sweeps. It keeps its own copy of the stated polynomial, so each decision is judged against the draw belonging to its own arrival cycle and not the neighbour's. A shift of one cycle in the draw shows up as wrong drop bits whenever the percentage lies strictly between 0 and 100.

// File: rtl/wred_admit.sv
`timescale 1ns/1ps
module wred_admit #(
  parameter int NQ    = 4,
  parameter int OCC_W = 14,
  parameter int THR_W = 10,
  parameter int GS    = 4,
  parameter int PCT_W = 7,
  parameter logic [15:0] SEED = 16'hACE1,
  localparam int QW = (NQ > 1) ? $clog2(NQ) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  arr_vld,
  input  logic [QW-1:0]         arr_queue,
  input  logic                  arr_hi_drop,
  input  logic [NQ*OCC_W-1:0]   occ_flat,
  input  logic [NQ*THR_W-1:0]   l1_flat,
  input  logic [NQ*THR_W-1:0]   l2_flat,
  input  logic [PCT_W-1:0]      pct_x,
  input  logic [PCT_W-1:0]      pct_y,
  input  logic [PCT_W-1:0]      pct_z,
  output logic                  dec_vld,
  output logic                  dec_drop
);
  localparam int CW = (OCC_W > THR_W + GS) ? OCC_W : THR_W + GS;

  logic [15:0] lfsr;
  wire         fb = lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) lfsr <= SEED;
    else        lfsr <= {lfsr[14:0], fb};

  wire [6:0] raw  = lfsr[6:0];
  wire [6:0] draw = (raw >= 7'd100) ? raw - 7'd100 : raw;

  wire [OCC_W-1:0] occ_sel = occ_flat[arr_queue*OCC_W +: OCC_W];
  wire [THR_W-1:0] l1_sel  = l1_flat[arr_queue*THR_W +: THR_W];
  wire [THR_W-1:0] l2_sel  = l2_flat[arr_queue*THR_W +: THR_W];

  wire [CW-1:0] occ_e = CW'(occ_sel);
  wire [CW-1:0] lvl1  = CW'({l1_sel, {GS{1'b0}}});
  wire [CW-1:0] lvl2  = CW'({l2_sel, {GS{1'b0}}});

  wire above1 = occ_e > lvl1;
  wire above2 = occ_e > lvl2;
  wire policed = (arr_queue != '0);

  logic             force_drop;
  logic             use_pct;
  logic [PCT_W-1:0] pct_sel;

  always_comb begin
    force_drop = 1'b0;
    use_pct    = 1'b0;
    pct_sel    = '0;
    if (policed) begin
      if (above2) begin
        if (arr_hi_drop) force_drop = 1'b1;
        else begin use_pct = 1'b1; pct_sel = pct_z; end
      end else if (above1) begin
        use_pct = 1'b1;
        pct_sel = arr_hi_drop ? pct_x : pct_y;
      end
    end
  end

  localparam int PW = (PCT_W > 7) ? PCT_W : 7;
  wire rand_hit = use_pct && (PW'(draw) < PW'(pct_sel));
  wire drop_now = force_drop | rand_hit;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      dec_vld  <= 1'b0;
      dec_drop <= 1'b0;
    end else begin
      dec_vld  <= arr_vld;
      dec_drop <= arr_vld & drop_now;
    end
endmodule

// File: rtl/wred_admit_chk.sv
`timescale 1ns/1ps
module wred_admit_chk #(
  parameter int NQ    = 4,
  parameter int OCC_W = 14,
  parameter int THR_W = 10,
  parameter int GS    = 4,
  parameter int QW    = 2
) (
  input logic                clk,
  input logic                rst_n,
  input logic                arr_vld,
  input logic [QW-1:0]       arr_queue,
  input logic                arr_hi_drop,
  input logic [NQ*OCC_W-1:0] occ_flat,
  input logic [NQ*THR_W-1:0] l1_flat,
  input logic [NQ*THR_W-1:0] l2_flat,
  input logic [15:0]         lfsr,
  input logic                dec_vld,
  input logic                dec_drop
);
  localparam int CW = (OCC_W > THR_W + GS) ? OCC_W : THR_W + GS;
  wire [CW-1:0] c_occ = CW'(occ_flat[arr_queue*OCC_W +: OCC_W]);
  wire [CW-1:0] c_l1  = CW'(l1_flat[arr_queue*THR_W +: THR_W]) << GS;
  wire [CW-1:0] c_l2  = CW'(l2_flat[arr_queue*THR_W +: THR_W]) << GS;

  a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    arr_vld |=> dec_vld);
  a_r2_valid_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !arr_vld |=> !dec_vld);
  a_r9_no_drop_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_vld |-> !dec_drop);
  a_r3_q0_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_vld && arr_queue == '0) |=> !dec_drop);
  a_r4_below_levels: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_vld && c_occ <= c_l1 && c_occ <= c_l2) |=> !dec_drop);
  a_r6_upper_hi: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_vld && arr_queue != '0 && arr_hi_drop && c_occ > c_l2) |=> dec_drop);
  a_r8_lfsr_live: assert property (@(posedge clk) disable iff (!rst_n)
    lfsr != 16'h0);
endmodule

bind wred_admit wred_admit_chk #(.NQ(NQ), .OCC_W(OCC_W), .THR_W(THR_W), .GS(GS), .QW(QW)) u_chk (
  .clk(clk), .rst_n(rst_n), .arr_vld(arr_vld), .arr_queue(arr_queue),
  .arr_hi_drop(arr_hi_drop), .occ_flat(occ_flat), .l1_flat(l1_flat),
  .l2_flat(l2_flat), .lfsr(lfsr), .dec_vld(dec_vld), .dec_drop(dec_drop));

// File: tb/tb_wred_admit.sv
`timescale 1ns/1ps
module tb_wred_admit;
  localparam int NQ = 4, OCC_W = 14, THR_W = 10, PCT_W = 7, QW = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic arr_vld = 1'b0, arr_hi_drop = 1'b0;
  logic [QW-1:0] arr_queue = '0;
  logic [NQ*OCC_W-1:0] occ_flat = '0;
  logic [NQ*THR_W-1:0] l1_flat = '0, l2_flat = '0;
  logic [PCT_W-1:0] pct_x = '0, pct_y = '0, pct_z = '0;
  logic dec_vld, dec_drop;

  int checks = 0, errors = 0;
  logic [15:0] m_lfsr;
  logic done = 1'b0;

  always #5 clk = ~clk;

  wred_admit dut (.clk(clk), .rst_n(rst_n), .arr_vld(arr_vld), .arr_queue(arr_queue),
    .arr_hi_drop(arr_hi_drop), .occ_flat(occ_flat), .l1_flat(l1_flat), .l2_flat(l2_flat),
    .pct_x(pct_x), .pct_y(pct_y), .pct_z(pct_z), .dec_vld(dec_vld), .dec_drop(dec_drop));

  always @(posedge clk or negedge rst_n)
    if (!rst_n) m_lfsr <= 16'hACE1;
    else        m_lfsr <= {m_lfsr[14:0], m_lfsr[15]^m_lfsr[13]^m_lfsr[12]^m_lfsr[10]};

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  function automatic int draw_of(input logic [15:0] s);
    int r = int'(s[6:0]);
    return (r >= 100) ? r - 100 : r;
  endfunction

  task automatic frame(input logic v, input int q, input logic hi, input int occ);
    logic exp;
    string tag;
    int l1, l2, d, p;
    @(negedge clk);
    arr_vld = v; arr_queue = QW'(q); arr_hi_drop = hi;
    occ_flat[q*OCC_W +: OCC_W] = OCC_W'(occ);
    l1 = int'(l1_flat[q*THR_W +: THR_W]) * 16;
    l2 = int'(l2_flat[q*THR_W +: THR_W]) * 16;
    d = draw_of(m_lfsr);
    exp = 1'b0; tag = "R4";
    if (!v) tag = "R9";
    else if (q == 0) tag = "R3";
    else if (occ > l2) begin
      if (hi) begin exp = 1'b1; tag = "R6"; end
      else begin p = int'(pct_z); exp = (d < p); tag = "R7/R8"; end
    end else if (occ > l1) begin
      p = hi ? int'(pct_x) : int'(pct_y); exp = (d < p); tag = "R5/R8";
    end
    @(posedge clk); #1;
    check("R2 valid", dec_vld, v);
    check(tag, dec_drop, exp);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      finish_run();
    end
  end

  initial begin
    l1_flat[1*THR_W +: THR_W] = 2;  l2_flat[1*THR_W +: THR_W] = 4;
    l1_flat[2*THR_W +: THR_W] = 5;  l2_flat[2*THR_W +: THR_W] = 9;
    l1_flat[3*THR_W +: THR_W] = 6;  l2_flat[3*THR_W +: THR_W] = 3;
    l1_flat[0*THR_W +: THR_W] = 0;  l2_flat[0*THR_W +: THR_W] = 0;
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset vld", dec_vld, 1'b0);
    check("R1 reset drop", dec_drop, 1'b0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    check("R1 post-reset vld", dec_vld, 1'b0);
    check("R1 post-reset drop", dec_drop, 1'b0);
    for (int set = 0; set < 4; set++) begin
      case (set)
        0: begin pct_x = 0;   pct_y = 100; pct_z = 0;   end
        1: begin pct_x = 100; pct_y = 0;   pct_z = 100; end
        2: begin pct_x = 30;  pct_y = 60;  pct_z = 45;  end
        default: begin pct_x = 99; pct_y = 1; pct_z = 50; end
      endcase
      for (int q = 0; q < NQ; q++)
        for (int occ = 0; occ <= 170; occ++)
          for (int hi = 0; hi < 2; hi++)
            frame(1'b1, q, hi[0], occ);
      for (int k = 0; k < 8; k++) frame(1'b0, 1, 1'b1, 200);
    end
    done = 1'b1;
    finish_run();
  end
endmodule